// File: doc/BRIEF.md
# Baud-Rate Generator with Infrared Transmit Pulse Shaper

This block produces the timing for a serial port from a 13-bit divisor loaded over a byte-wide register bus. It emits a single-cycle oversampling tick at sixteen times the bit rate for the receiver and transmitter, and a bit tick on every sixteenth oversampling tick. The divisor is written as two bytes. The upper part waits in a holding register and is applied together with the lower byte, so the counter never sees a half-updated divisor.

An infrared mode changes both the divisor arithmetic and the transmit line. When the mode is on, bit 0 of the divisor is ignored and the oversampling period becomes twice the upper twelve bits. Each zero data bit is then sent as a short high pulse at the start of its bit period. A 2-bit select sets the pulse width to a fraction of the bit time. A one data bit sends no pulse, so the line stays low. When the mode is off, the raw transmit bit goes straight to the output.

The generator stays idle after reset until a transmit or receive enable is seen for the first time. It stops whenever the divisor that is in effect is zero.

Top module: `baud_ir_gen`

## Requirements
- R1: With infrared mode off and a divisor D of at least 1, `sample_tick` pulses once every D bus-clock cycles. For D of at least 2 each pulse is one cycle wide.
- R2: With infrared mode on, `sample_tick` pulses once every 2*floor(D/2) cycles. Divisor bit 0 has no effect.
- R3: After reset, no tick appears until `tx_en` or `rx_en` has been high for at least one clock. From then on the generator keeps running even if both enables go low.
- R4: No tick is produced while the divisor is zero with infrared mode off, or while divisor bits 12..1 are all zero with infrared mode on.
- R5: A write with `wr_hi`=1 stores `wr_data[4:0]` as divisor bits 12..8 in a holding register. The tick rate does not change until a write with `wr_hi`=0 loads bits 7..0, and that write applies both parts together.
- R6: `bit_tick` is high only in a cycle where `sample_tick` is high, and it is high on exactly every 16th sample tick.
- R7: With infrared mode on, a zero transmit bit sampled in a cycle where `bit_tick` is high drives `tx_out` high starting in the next cycle. The number of high cycles depends on `pulse_sel`, where P is the sample period: 00 gives 4P, 01 gives 3P, 10 gives P, and 11 gives P/2.
- R8: With infrared mode on, a one transmit bit produces no pulse, and `tx_out` stays low for the whole bit period.
- R9: With infrared mode off, `tx_out` equals `tx_raw` in every cycle.
- R10: After the divisor changes while the generator is running, at most the one tick interval that spans the change differs from the new period. Every later interval equals the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Divisor register write strobe |
| wr_hi | input | 1 | 1 selects the high divisor byte (held), 0 selects the low byte (applies both) |
| wr_data | input | 8 | Write data |
| ir_en | input | 1 | Infrared mode enable |
| pulse_sel | input | 2 | Infrared pulse width select |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| tx_raw | input | 1 | Unencoded transmit bit |
| sample_tick | output | 1 | 16x oversampling tick |
| bit_tick | output | 1 | Bit-period tick |
| tx_out | output | 1 | Transmit line, infrared-encoded when the mode is on |

## Verification
The hardest case to reach from the ports is a divisor change that lands in the middle of a running count. The write must come at an arbitrary phase of the counter, and the high byte alone must visibly have no effect. The bench builds this in steps. It first locks onto a tick, then writes only the high byte and shows that the following interval is unchanged. It then completes the write with the low byte, discards the interval that spans the change, and measures the steady intervals that follow. The pulse widths are measured by aligning to `bit_tick` and counting the high cycles of `tx_out` for each select code. The 1/32 width is only reachable in infrared mode with an even sample period.

// File: rtl/baud_ir_pkg.sv
package baud_ir_pkg;

    // Encodings of the 2-bit pulse width select.
    typedef enum logic [1:0] {
        PW_QUARTER = 2'b00,   // 4 sample periods
        PW_3_16    = 2'b01,   // 3 sample periods
        PW_1_16    = 2'b10,   // 1 sample period
        PW_1_32    = 2'b11    // half a sample period
    } pulse_w_e;

    localparam int unsigned OVERSAMPLE = 16;

endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs #(
    parameter int unsigned DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_hi,
    input  logic [7:0]       wr_data,
    output logic [DIV_W-1:0] div_o
);
    localparam int unsigned HI_W = DIV_W - 8;

    typedef struct packed {
        logic [HI_W-1:0]  hold;
        logic [DIV_W-1:0] div;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (wr_hi) begin
                r_d.hold = wr_data[HI_W-1:0];
            end else begin
                r_d.div = {r_q.hold, wr_data};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign div_o = r_q.div;

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_ir_pkg::*;
#(
    parameter int unsigned DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_req,
    input  logic             ir_en,
    input  logic [DIV_W-1:0] div_i,
    output logic [DIV_W-1:0] period_o,
    output logic             sample_tick_o,
    output logic             bit_tick_o
);
    localparam int unsigned SUB_W = $clog2(OVERSAMPLE);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);

    typedef struct packed {
        logic             started;
        logic [DIV_W-1:0] cnt;
        logic [SUB_W-1:0] sub;
        logic             tick;
        logic             btick;
    } tg_t;

    tg_t r_q, r_d;
    logic [DIV_W-1:0] period;
    logic             running;

    // In infrared mode bit 0 is dropped and the remaining value is doubled.
    assign period  = ir_en ? {div_i[DIV_W-1:1], 1'b0} : div_i;
    assign running = r_q.started && (period != '0);

    always_comb begin
        r_d       = r_q;
        r_d.tick  = 1'b0;
        r_d.btick = 1'b0;
        if (en_req) begin
            r_d.started = 1'b1;
        end
        if (!running) begin
            r_d.cnt = '0;
            r_d.sub = '0;
        end else if (r_q.cnt >= period - ONE) begin
            // Terminal count: the current divisor sets the next reload.
            r_d.cnt  = '0;
            r_d.tick = 1'b1;
            if (r_q.sub == SUB_LAST) begin
                r_d.sub   = '0;
                r_d.btick = 1'b1;
            end else begin
                r_d.sub = r_q.sub + 1'b1;
            end
        end else begin
            r_d.cnt = r_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign period_o      = period;
    assign sample_tick_o = r_q.tick;
    assign bit_tick_o    = r_q.btick;

endmodule

// File: rtl/ir_pulse_shaper.sv
module ir_pulse_shaper
    import baud_ir_pkg::*;
#(
    parameter int unsigned DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ir_en,
    input  logic [1:0]       sel_i,
    input  logic [DIV_W-1:0] period_i,
    input  logic             bit_tick_i,
    input  logic             tx_raw,
    output logic             tx_out
);
    localparam int unsigned CW = DIV_W + 2;
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic          pulse;
        logic [CW-1:0] left;
    } sh_t;

    sh_t r_q, r_d;
    logic [CW-1:0] p_ext;
    logic [CW-1:0] width;

    assign p_ext = CW'(period_i);

    always_comb begin
        unique case (pulse_w_e'(sel_i))
            PW_QUARTER: width = p_ext << 2;
            PW_3_16:    width = (p_ext << 1) + p_ext;
            PW_1_16:    width = p_ext;
            default:    width = p_ext >> 1;
        endcase
    end

    always_comb begin
        r_d = r_q;
        if (!ir_en) begin
            r_d = '0;
        end else if (bit_tick_i && !tx_raw) begin
            r_d.pulse = (width != '0);
            r_d.left  = width - ONE;
        end else if (r_q.pulse) begin
            if (r_q.left == '0) begin
                r_d.pulse = 1'b0;
            end else begin
                r_d.left = r_q.left - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_out = ir_en ? r_q.pulse : tx_raw;

endmodule

// File: rtl/baud_ir_gen.sv
module baud_ir_gen #(
    parameter int unsigned DIV_W = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_hi,
    input  logic [7:0] wr_data,
    input  logic       ir_en,
    input  logic [1:0] pulse_sel,
    input  logic       tx_en,
    input  logic       rx_en,
    input  logic       tx_raw,
    output logic       sample_tick,
    output logic       bit_tick,
    output logic       tx_out
);
    logic [DIV_W-1:0] divisor;
    logic [DIV_W-1:0] period;

    baud_div_regs #(.DIV_W(DIV_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_hi   (wr_hi),
        .wr_data (wr_data),
        .div_o   (divisor)
    );

    baud_tick_gen #(.DIV_W(DIV_W)) u_ticks (
        .clk           (clk),
        .rst_n         (rst_n),
        .en_req        (tx_en | rx_en),
        .ir_en         (ir_en),
        .div_i         (divisor),
        .period_o      (period),
        .sample_tick_o (sample_tick),
        .bit_tick_o    (bit_tick)
    );

    ir_pulse_shaper #(.DIV_W(DIV_W)) u_shaper (
        .clk        (clk),
        .rst_n      (rst_n),
        .ir_en      (ir_en),
        .sel_i      (pulse_sel),
        .period_i   (period),
        .bit_tick_i (bit_tick),
        .tx_raw     (tx_raw),
        .tx_out     (tx_out)
    );

endmodule

// File: rtl/baud_ir_chk.sv
module baud_ir_chk #(
    parameter int unsigned DIV_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_hi,
    input logic             ir_en,
    input logic             tx_en,
    input logic             rx_en,
    input logic             tx_raw,
    input logic             sample_tick,
    input logic             bit_tick,
    input logic             tx_out,
    input logic [DIV_W-1:0] divisor
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else if (tx_en || rx_en) begin
            seen_q <= 1'b1;
        end
    end

    // R3
    idle_before_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !sample_tick);

    // R4
    stopped_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_en ? (divisor[DIV_W-1:1] == '0) : (divisor == '0)) |=> !sample_tick);

    // R5
    high_byte_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hi) |=> $stable(divisor));

    // R6
    bit_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sample_tick);

    // R6
    bit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);

    // R7
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_en && $past(ir_en) && $rose(tx_out)) |-> ($past(bit_tick) && !$past(tx_raw)));

    // R9
    passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_en |-> (tx_out == tx_raw));

endmodule

bind baud_ir_gen baud_ir_chk #(.DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_hi       (wr_hi),
    .ir_en       (ir_en),
    .tx_en       (tx_en),
    .rx_en       (rx_en),
    .tx_raw      (tx_raw),
    .sample_tick (sample_tick),
    .bit_tick    (bit_tick),
    .tx_out      (tx_out),
    .divisor     (divisor)
);

// File: tb/sim_baud_ir_gen.sv
`timescale 1ns/1ps
module sim_baud_ir_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_hi = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ir_en = 1'b0;
    logic [1:0] pulse_sel = 2'b00;
    logic       tx_en = 1'b0;
    logic       rx_en = 1'b0;
    logic       tx_raw = 1'b1;
    logic       sample_tick, bit_tick, tx_out;

    int total = 0;
    int fails = 0;
    localparam int GUARD = 20000;

    always #2 clk = ~clk;   // 250 MHz

    baud_ir_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
        .ir_en(ir_en), .pulse_sel(pulse_sel), .tx_en(tx_en), .rx_en(rx_en),
        .tx_raw(tx_raw), .sample_tick(sample_tick), .bit_tick(bit_tick), .tx_out(tx_out)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit hi, input int v);
        @(negedge clk);
        wr_en = 1'b1; wr_hi = hi; wr_data = v[7:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_div(input int d);
        wr(1'b1, d >> 8);
        wr(1'b0, d & 255);
    endtask

    task automatic next_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sample_tick && n < GUARD);
    endtask

    task automatic wait_bit();
        int g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!bit_tick && g < GUARD);
    endtask

    task automatic count_ticks(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (sample_tick) n++;
        end
    endtask

    // Skip the interval spanning a change, then measure two steady ones.
    task automatic measure(input string req, input int exp);
        int a, b;
        next_tick(a);
        next_tick(a);
        next_tick(a);
        next_tick(b);
        check(req, a, exp);
        check(req, b, exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // reset state
        check("R3 reset sample_tick", int'(sample_tick), 0);
        check("R6 reset bit_tick", int'(bit_tick), 0);
        check("R9 reset tx_out", int'(tx_out), 1);
        rst_n = 1'b1;

        // R3: idle before any enable
        set_div(5);
        count_ticks(100, n);
        check("R3 idle before enable", n, 0);

        // R3: one-cycle enable pulse starts a generator that keeps running
        @(negedge clk); rx_en = 1'b1;
        @(negedge clk); rx_en = 1'b0;
        measure("R3 sticky run", 5);

        // R5 / R10: high byte alone is held
        set_div(4);
        measure("R10 new period", 4);
        wr(1'b1, 1);
        measure("R5 high byte held", 4);
        wr(1'b0, 0);
        measure("R5 applied on low write", 256);

        // R1 sweep, normal mode
        for (int d = 1; d <= 24; d++) begin
            set_div(d);
            measure("R1 normal period", d);
            if (d >= 2) begin
                @(negedge clk);
                check("R1 tick width", int'(sample_tick), 0);
            end
        end
        set_div(8191);
        measure("R1 max divisor", 8191);

        // R2 sweep, infrared mode
        ir_en = 1'b1;
        for (int d = 2; d <= 25; d++) begin
            set_div(d);
            measure("R2 ir period", 2 * (d / 2));
        end
        set_div(8191);
        measure("R2 ir max divisor", 8190);

        // R4: zero divisor stops ticks
        ir_en = 1'b0;
        set_div(0);
        count_ticks(60, n);
        check("R4 zero divisor normal", n, 0);
        ir_en = 1'b1;
        set_div(1);
        count_ticks(60, n);
        check("R4 zero upper bits ir", n, 0);
        ir_en = 1'b0;
        measure("R4 resumes", 1);

        // R6: bit tick every 16 sample ticks
        set_div(3);
        wait_bit();
        for (int k = 0; k < 3; k++) begin
            n = 0;
            do begin
                int t;
                next_tick(t);
                n++;
            end while (!bit_tick && n < 40);
            check("R6 ticks per bit", n, 16);
        end

        // R9: passthrough in normal mode
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); tx_raw = k[0];
            #1;
            check("R9 passthrough", int'(tx_out), k[0]);
        end

        // R7: pulse widths in infrared mode, P = 6 then P = 20
        ir_en = 1'b1;
        set_div(6);
        tx_raw = 1'b0;
        for (int s = 0; s < 4; s++) begin
            int exp;
            pulse_sel = s[1:0];
            exp = (s == 0) ? 24 : (s == 1) ? 18 : (s == 2) ? 6 : 3;
            wait_bit();
            n = 0;
            @(negedge clk);
            while (tx_out && n < GUARD) begin
                n++;
                @(negedge clk);
            end
            check("R7 pulse width P=6", n, exp);
        end
        set_div(21);
        for (int s = 0; s < 4; s++) begin
            int exp;
            pulse_sel = s[1:0];
            exp = (s == 0) ? 80 : (s == 1) ? 60 : (s == 2) ? 20 : 10;
            wait_bit();
            n = 0;
            @(negedge clk);
            while (tx_out && n < GUARD) begin
                n++;
                @(negedge clk);
            end
            check("R7 pulse width P=20", n, exp);
        end

        // R8: a one bit sends no pulse
        set_div(6);
        tx_raw = 1'b1;
        wait_bit();
        n = 0;
        for (int i = 0; i < 95; i++) begin
            @(negedge clk);
            if (tx_out) n++;
        end
        check("R8 no pulse for one", n, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule